// File: doc/BRIEF.md
# Interrupt Acknowledge Terminator with Slow-Enable Synchronisation

This block closes autovectored interrupt-acknowledge bus cycles on a 16-bit processor bus that also serves slow peripherals. It runs a free-running enable clock `e_clk`, made by dividing the system clock, with a low phase of `E_LOW` clocks followed by a high phase of `E_HIGH` clocks. When the address strobe is low and the function code shows an interrupt acknowledge, the block drives the active-low valid-peripheral-address request `vpa_n`. It keeps the bus cycle open until the enable clock has gone through one full high phase.

The enable clock is not aligned with the interrupt. The number of system clocks an acknowledge takes therefore depends on the enable phase at the moment the strobe falls. The block gives a one-clock `cycle_done` pulse when the cycle may end, and reports the measured length in `ack_latency`. System integrators use this length to budget interrupt jitter. Vector fetch and stack traffic belong to other logic.

Top module: `ack_e_sync_term`

## Requirements
- R1: `e_clk` is periodic with period `E_LOW+E_HIGH` clocks (default 10). It is low for `E_LOW` (6) consecutive clocks and high for `E_HIGH` (4). Counting the clock edges since reset was released as n, `e_clk` is high exactly when (n mod 10) is 6 or more.
- R2: A synchronous active-high `rst` sets the divider count to 0 with `e_clk` low. After reset, `vpa_n` is 1, `cycle_done` is 0 and `ack_latency` is 0.
- R3: An acknowledge is recognised when `as_n` is 0 and `fc` equals 3'b111. On the first rising edge that samples this condition, `vpa_n` goes to 0.
- R4: `vpa_n` returns to 1 on the first rising edge after `as_n` rises or any `fc` bit falls.
- R5: When `fc` holds any other value, including 3'b110, `vpa_n` stays 1 and `cycle_done` never pulses, even with `as_n` low.
- R6: Let k0 be the edge that first samples an acknowledge. The block waits for the first rise of `e_clk` at an edge strictly later than k0. `cycle_done` is then high for exactly one clock, starting at the edge where `e_clk` falls again.
- R7: `ack_latency` is loaded with the number of clock edges from k0 to the `cycle_done` edge. It holds that value until the next completed acknowledge. With the default parameters, a divider phase p (the value n mod 10 just before k0) gives a latency of ((5-p) mod 10, with 0 replaced by 10) + 4. This ranges from 5 to 14.
- R8: If the acknowledge condition drops before termination, the cycle aborts. No `cycle_done` pulse is given and `ack_latency` keeps its old value.
- R9: A strobe held low after termination gives no further `cycle_done` pulse until the acknowledge condition has dropped and been raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| fc | input | FC_W (3) | Bus function code |
| e_clk | output | 1 | Divided enable clock, registered |
| vpa_n | output | 1 | Valid-peripheral-address request, active low, registered |
| cycle_done | output | 1 | One-clock pulse when the acknowledge may end |
| ack_latency | output | LAT_W (8) | Length of the last completed acknowledge, in clocks |

## Verification
The bench builds the block with its default 6-low/4-high divider, which gives ten distinct enable phases. It starts an acknowledge from every one of those phases, so both latency extremes are reached: 14 clocks when the strobe falls just as the enable would rise, and 5 clocks when it falls one clock before. The short divider period also lets the bench run abort, wrong-function-code and held-strobe cases within a few hundred clocks.

// File: rtl/ack_term_pkg.sv
package ack_term_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_HIGH = 2'd2,
    ST_HOLD = 2'd3
  } term_state_e;
endpackage

// File: rtl/e_phase_gen.sv
// Free-running divider: low for LOW_CLKS, high for HIGH_CLKS.
module e_phase_gen #(
  parameter int LOW_CLKS  = 6,
  parameter int HIGH_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic e_o,
  output logic rise_next_o,
  output logic fall_next_o
);
  localparam int PER = LOW_CLKS + HIGH_CLKS;
  localparam int CW  = $clog2(PER);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q == CW'(PER - 1)) cnt_nxt = '0;
    else                       cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      e_o   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      e_o   <= (cnt_nxt >= CW'(LOW_CLKS));
    end
  end

  // Indicates that the coming edge changes e_o.
  assign rise_next_o = (cnt_q == CW'(LOW_CLKS - 1));
  assign fall_next_o = (cnt_q == CW'(PER - 1));
endmodule

// File: rtl/ack_cycle_decode.sv
module ack_cycle_decode #(
  parameter int             FC_W   = 3,
  parameter logic [FC_W-1:0] ACK_FC = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_n,
  input  logic [FC_W-1:0] fc,
  output logic            hit_o,
  output logic            vpa_n_o
);
  assign hit_o = !as_n && (fc == ACK_FC);

  always_ff @(posedge clk) begin
    if (rst) vpa_n_o <= 1'b1;
    else     vpa_n_o <= !hit_o;
  end
endmodule

// File: rtl/ack_term_ctrl.sv
module ack_term_ctrl
  import ack_term_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             rise_next_i,
  input  logic             fall_next_i,
  output logic             done_o,
  output logic [LAT_W-1:0] lat_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  term_state_e      st_q;
  logic [LAT_W-1:0] run_q;
  logic [LAT_W-1:0] run_inc;

  assign run_inc = (run_q == LAT_MAX) ? run_q : run_q + LAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      run_q  <= '0;
      done_o <= 1'b0;
      lat_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (hit_i) begin
            st_q  <= ST_SYNC;
            run_q <= '0;
          end
        end
        ST_SYNC: begin
          if (!hit_i) st_q <= ST_IDLE;
          else begin
            run_q <= run_inc;
            if (rise_next_i) st_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (!hit_i) st_q <= ST_IDLE;
          else begin
            run_q <= run_inc;
            if (fall_next_i) begin
              done_o <= 1'b1;
              lat_o  <= run_inc;
              st_q   <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (!hit_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ack_e_sync_term.sv
module ack_e_sync_term #(
  parameter int              E_LOW  = 6,
  parameter int              E_HIGH = 4,
  parameter int              FC_W   = 3,
  parameter logic [FC_W-1:0] ACK_FC = '1,
  parameter int              LAT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_n,
  input  logic [FC_W-1:0]  fc,
  output logic             e_clk,
  output logic             vpa_n,
  output logic             cycle_done,
  output logic [LAT_W-1:0] ack_latency
);
  logic hit;
  logic rise_next;
  logic fall_next;

  e_phase_gen #(.LOW_CLKS(E_LOW), .HIGH_CLKS(E_HIGH)) u_div (
    .clk(clk), .rst(rst), .e_o(e_clk),
    .rise_next_o(rise_next), .fall_next_o(fall_next)
  );

  ack_cycle_decode #(.FC_W(FC_W), .ACK_FC(ACK_FC)) u_dec (
    .clk(clk), .rst(rst), .as_n(as_n), .fc(fc),
    .hit_o(hit), .vpa_n_o(vpa_n)
  );

  ack_term_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rst(rst), .hit_i(hit),
    .rise_next_i(rise_next), .fall_next_i(fall_next),
    .done_o(cycle_done), .lat_o(ack_latency)
  );
endmodule

// File: rtl/ack_e_sync_term_chk.sv
module ack_e_sync_term_chk #(
  parameter int              E_LOW  = 6,
  parameter int              E_HIGH = 4,
  parameter int              FC_W   = 3,
  parameter logic [FC_W-1:0] ACK_FC = '1,
  parameter int              LAT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             as_n,
  input logic [FC_W-1:0]  fc,
  input logic             e_clk,
  input logic             vpa_n,
  input logic             cycle_done,
  input logic [LAT_W-1:0] ack_latency
);
  localparam int PER = E_LOW + E_HIGH;

  logic       ack_req;
  logic       e_q;
  logic       seen_q;
  logic [7:0] run_q;

  assign ack_req = !as_n && (fc == ACK_FC);

  // Phase-length checking through a counter (R1).
  always_ff @(posedge clk) begin
    if (rst) begin
      e_q    <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= 8'd1;
    end else begin
      e_q <= e_clk;
      if (e_clk != e_q) begin
        if (seen_q) begin
          p_e_phase_len_r1: assert (run_q == (e_q ? 8'(E_HIGH) : 8'(E_LOW)))
            else $error("e_clk phase length %0d", run_q);
        end
        seen_q <= 1'b1;
        run_q  <= 8'd1;
      end else begin
        run_q <= run_q + 8'd1;
      end
    end
  end

  p_vpa_assert_r3: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> !vpa_n);

  p_vpa_release_r4: assert property (@(posedge clk) disable iff (rst)
    !ack_req |=> vpa_n);

  p_done_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cycle_done) |-> (!e_clk && $past(e_clk)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    cycle_done |=> !cycle_done);

  p_lat_range_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (ack_latency >= LAT_W'(E_HIGH + 1)) && (ack_latency <= LAT_W'(PER + E_HIGH)));

  p_done_needs_ack_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cycle_done) |-> $past(ack_req));

  p_lat_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !cycle_done |-> $stable(ack_latency));
endmodule

bind ack_e_sync_term ack_e_sync_term_chk #(
  .E_LOW(E_LOW), .E_HIGH(E_HIGH), .FC_W(FC_W), .ACK_FC(ACK_FC), .LAT_W(LAT_W)
) u_chk (
  .clk(clk), .rst(rst), .as_n(as_n), .fc(fc), .e_clk(e_clk),
  .vpa_n(vpa_n), .cycle_done(cycle_done), .ack_latency(ack_latency)
);

// File: tb/ack_e_sync_term_tb_top.sv
`timescale 1ns/1ps
module ack_e_sync_term_tb_top;
  localparam int LAT_W = 8;
  localparam int PER   = 10;

  // {phase before strobe edge, expected latency}
  localparam logic [7:0] VEC [0:9] = '{
    8'h09, 8'h18, 8'h27, 8'h36, 8'h45,
    8'h5E, 8'h6D, 8'h7C, 8'h8B, 8'h9A
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             as_n = 1'b1;
  logic [2:0]       fc = 3'b000;
  logic             e_clk;
  logic             vpa_n;
  logic             cycle_done;
  logic [LAT_W-1:0] ack_latency;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  ack_e_sync_term dut_i (
    .clk(clk), .rst(rst), .as_n(as_n), .fc(fc), .e_clk(e_clk),
    .vpa_n(vpa_n), .cycle_done(cycle_done), .ack_latency(ack_latency)
  );

  always @(posedge clk) begin
    if (rst) ticks <= 0;
    else     ticks <= ticks + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: enable waveform checked every cycle after reset
  always @(negedge clk) begin
    if (!rst && !ended) check("R1 e_clk", int'(e_clk), int'((ticks % PER) >= 6));
  end

  task automatic wait_phase(input int ph);
    do @(negedge clk); while ((ticks % PER) != ph);
  endtask

  task automatic run_ack(input int ph, input int exp_lat);
    int n;
    bit got;
    int extra;
    wait_phase(ph);
    as_n = 1'b0; fc = 3'b111;
    n = 0; got = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) check("R3 vpa_n asserted", int'(vpa_n), 0);
      if (cycle_done) begin got = 1'b1; break; end
    end
    check("R6 done seen", int'(got), 1);
    check("R6 done timing", n, exp_lat + 1);
    check("R7 latency", int'(ack_latency), exp_lat);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cycle_done) extra++;
    end
    check("R9 no repeat done", extra, 0);
    as_n = 1'b1;
    @(negedge clk);
    check("R4 vpa_n released", int'(vpa_n), 1);
    fc = 3'b000;
  endtask

  initial begin
    int last;
    int cnt;
    repeat (3) @(negedge clk);
    check("R2 e_clk reset", int'(e_clk), 0);
    check("R2 vpa_n reset", int'(vpa_n), 1);
    check("R2 done reset", int'(cycle_done), 0);
    check("R2 latency reset", int'(ack_latency), 0);
    rst = 1'b0;

    for (int v = 0; v < 10; v++) run_ack(int'(VEC[v][7:4]), int'(VEC[v][3:0]));

    // R8: abort by strobe before termination
    last = int'(ack_latency);
    wait_phase(0);
    as_n = 1'b0; fc = 3'b111;
    repeat (3) @(negedge clk);
    as_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cycle_done) cnt++;
    end
    check("R8 abort no done", cnt, 0);
    check("R8 latency kept", int'(ack_latency), last);

    // R4: release through a function-code bit, R8 abort via fc
    wait_phase(3);
    as_n = 1'b0; fc = 3'b111;
    @(negedge clk);
    fc = 3'b011;
    @(negedge clk);
    check("R4 vpa_n released by fc", int'(vpa_n), 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cycle_done) cnt++;
    end
    check("R8 fc abort no done", cnt, 0);
    as_n = 1'b1; fc = 3'b000;

    // R5: non-acknowledge function code
    @(negedge clk);
    as_n = 1'b0; fc = 3'b110;
    cnt = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (cycle_done || !vpa_n) cnt++;
    end
    check("R5 other fc ignored", cnt, 0);
    check("R5 latency kept", int'(ack_latency), last);
    as_n = 1'b1; fc = 3'b000;

    // R9: after drop and re-raise, a new cycle completes again
    run_ack(4, 5);

    // R2: reset in mid-run returns reset state
    as_n = 1'b0; fc = 3'b111;
    @(negedge clk);
    rst = 1'b1;
    as_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 e_clk after reset", int'(e_clk), 0);
    check("R2 latency after reset", int'(ack_latency), 0);
    check("R2 vpa_n after reset", int'(vpa_n), 1);

    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3000000;
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule